// File: doc/BRIEF.md
# Byte RAM with Parity Guard and Error Control

This block wraps a small synchronous byte memory. Each location holds nine bits: the data byte and one even-parity bit. The parity bit is computed when a byte is written. When the byte is read back, the parity over all nine bits is checked again. A mismatch sets a sticky error flag. If the mask bit does not block it, the same mismatch also drives a one-cycle reset request to an external reset controller. The controller is not part of this block.

Software reaches the mask bit and the error flag through an eight-bit control/status register. The register can be written as a whole byte or one bit at a time. Only hardware can set the error flag. Software can clear it, and so can reset. For fault testing, a write-side hook stores the inverted parity bit, which makes a later read of that location report an error. Parity checking cannot be switched off. A location that was never written holds arbitrary parity, so software must write any location before it reads it.

Top module: `parity_ram_guard`

## Requirements
- R1: When `mem_re` is high at a clock edge, `mem_rvalid` is high in the following cycle and `mem_rdata` holds the byte last written to `mem_addr`. `mem_rvalid` is low in any cycle that does not follow a read.
- R2: A byte written with `inj_par_flip` low is stored with even parity, which is the XOR of its eight bits. Reading it back neither sets the error flag nor raises `rst_req`.
- R3: Reading a location whose stored nine bits have odd XOR sets the error flag (register bit 0). The flag reads 1 two cycles after the `mem_re` cycle, which is one cycle after `mem_rvalid`.
- R4: While the mask bit (register bit 7) is 0, a read parity error drives `rst_req` high for exactly one cycle. That cycle is the same one in which the flag first reads 1.
- R5: While the mask bit is 1, a read parity error never raises `rst_req`, but it still sets the error flag.
- R6: Once set, the error flag stays 1 through later error-free reads.
- R7: Writing 0 to the flag bit clears it. Writing 1 to the flag bit has no effect.
- R8: If a parity error and a software clear of the flag happen in the same cycle, the flag ends up at 1.
- R9: After reset the register reads 0x00. Bits 6 to 1 always read 0.
- R10: Byte mode (`reg_bit_mode`=0) updates the mask from `reg_wdata[7]` and the flag from `reg_wdata[0]`. Bit mode (`reg_bit_mode`=1) updates only the bit at `reg_bit_sel`, using the value `reg_wdata[reg_bit_sel]`. Every other bit is left unchanged.
- R11: A write with `inj_par_flip` high stores inverted parity. The write alone does not touch the flag or `rst_req`. The error appears only when that location is read.
- R12: Asserting `rst_n` low clears both the mask and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | input | ADDR_W | Byte address for read or write |
| mem_wdata | input | 8 | Write data |
| mem_we | input | 1 | Write enable |
| mem_re | input | 1 | Read enable |
| inj_par_flip | input | 1 | Test hook: store inverted parity on this write |
| mem_rdata | output | 8 | Read data, valid while mem_rvalid is high |
| mem_rvalid | output | 1 | Read data valid, one cycle after mem_re |
| reg_we | input | 1 | Control/status register write strobe |
| reg_bit_mode | input | 1 | 1: single-bit write, 0: full byte write |
| reg_bit_sel | input | 3 | Bit index for single-bit writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback: bit 7 mask, bit 0 error flag |
| rst_req | output | 1 | One-cycle reset request on unmasked parity error |

## Verification
Read data and `mem_rvalid` are due one cycle after the `mem_re` edge. The error flag and `rst_req` are due one cycle later again, and a register write shows in `reg_rdata` one cycle after its strobe. The bench drives inputs on falling edges and samples on the falling edges that match these latencies. On each read it checks the data first, then the flag and `rst_req`, and then checks one more cycle to confirm that `rst_req` has dropped. The same-cycle clash between a set and a clear is driven on the exact edge where the error is detected.

// File: rtl/pr_pkg.sv
// Shared constants and helpers for the parity-guarded RAM.
// Assumes an 8-bit control/status register with mask and flag at fixed positions.
package pr_pkg;
    localparam int REG_W    = 8;
    localparam int MASK_BIT = 7;
    localparam int FLAG_BIT = 0;

    // Even parity of a data word: XOR of all of its bits.
    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction
endpackage

// File: rtl/pr_parity_store.sv
// Nine-bit-wide synchronous memory: data byte plus stored parity bit.
// Assumes one access port; a read in the same cycle as a write to the
// same address returns the previous contents. Contents are not reset.
module pr_parity_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              flip,
    output logic [DATA_W-1:0] rdata,
    output logic              rpar,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_word;
    logic              wpar;

    // Parity to store: even parity, optionally inverted by the test hook.
    always_comb wpar = (^wdata) ^ flip;

    // Array write; storage has no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= {wpar, wdata};
    end

    // Registered read word (read-before-write).
    always_ff @(posedge clk) begin
        if (rd_en) rd_word <= mem[addr];
    end

    // Read-valid flag, one cycle after a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= rd_en;
    end

    assign rdata = rd_word[DATA_W-1:0];
    assign rpar  = rd_word[DATA_W];
endmodule

// File: rtl/pr_parity_check.sv
// Combinational parity checker on the registered read word.
// Assumes data and parity are qualified by the read-valid flag.
module pr_parity_check #(
    parameter int DATA_W = 8
) (
    input  logic              rvalid,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rpar,
    output logic              err_hit
);
    // Error when the XOR of all nine stored bits is odd on a valid read.
    always_comb err_hit = rvalid & (^{rpar, rdata});
endmodule

// File: rtl/pr_ctl_reg.sv
// Control/status register: mask bit, sticky error flag, reset-request pulse.
// Assumes a hardware set of the flag takes priority over a software clear.
module pr_ctl_reg
    import pr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_hit,
    input  logic             reg_we,
    input  logic             reg_bit_mode,
    input  logic [2:0]       reg_bit_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic             mask_q,
    output logic             flag_q,
    output logic             rst_req,
    output logic [REG_W-1:0] reg_rdata
);
    logic [REG_W-1:0] bit_en;
    logic [REG_W-1:0] bit_val;

    // Per-bit write enable and value for byte or single-bit mode.
    genvar gi;
    generate
        for (gi = 0; gi < REG_W; gi++) begin : g_bit
            always_comb begin
                bit_en[gi]  = reg_we && (!reg_bit_mode || (reg_bit_sel == 3'(gi)));
                bit_val[gi] = reg_bit_mode ? reg_wdata[reg_bit_sel] : reg_wdata[gi];
            end
            // Readback: only mask and flag positions carry state.
            if (gi == MASK_BIT) begin : g_mask
                assign reg_rdata[gi] = mask_q;
            end else if (gi == FLAG_BIT) begin : g_flag
                assign reg_rdata[gi] = flag_q;
            end else begin : g_zero
                assign reg_rdata[gi] = 1'b0;
            end
        end
    endgenerate

    // Mask bit: written freely by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= 1'b0;
        else if (bit_en[MASK_BIT]) mask_q <= bit_val[MASK_BIT];
    end

    // Error flag: set by hardware, cleared only by a software 0 or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        flag_q <= 1'b0;
        else if (err_hit)                                  flag_q <= 1'b1;
        else if (bit_en[FLAG_BIT] && !bit_val[FLAG_BIT])   flag_q <= 1'b0;
    end

    // One-cycle reset request per unmasked error.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= err_hit && !mask_q;
    end
endmodule

// File: rtl/parity_ram_guard.sv
// Top: parity-protected byte RAM with control/status register and
// reset-request output. Assumes one memory access port and a simple
// single-cycle register write strobe; register reads are combinational.
module parity_ram_guard #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic              mem_we,
    input  logic              mem_re,
    input  logic              inj_par_flip,
    output logic [7:0]        mem_rdata,
    output logic              mem_rvalid,
    input  logic              reg_we,
    input  logic              reg_bit_mode,
    input  logic [2:0]        reg_bit_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              rst_req
);
    logic rd_par;
    logic err_hit;
    logic mask_q;
    logic flag_q;

    pr_parity_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (mem_addr),
        .wdata  (mem_wdata),
        .wr_en  (mem_we),
        .rd_en  (mem_re),
        .flip   (inj_par_flip),
        .rdata  (mem_rdata),
        .rpar   (rd_par),
        .rvalid (mem_rvalid)
    );

    pr_parity_check #(.DATA_W(8)) u_check (
        .rvalid  (mem_rvalid),
        .rdata   (mem_rdata),
        .rpar    (rd_par),
        .err_hit (err_hit)
    );

    pr_ctl_reg u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_hit      (err_hit),
        .reg_we       (reg_we),
        .reg_bit_mode (reg_bit_mode),
        .reg_bit_sel  (reg_bit_sel),
        .reg_wdata    (reg_wdata),
        .mask_q       (mask_q),
        .flag_q       (flag_q),
        .rst_req      (rst_req),
        .reg_rdata    (reg_rdata)
    );
endmodule

// File: rtl/pr_guard_sva.sv
// Checker bound to parity_ram_guard: timing of read-valid, detection,
// flag stickiness and reset-request gating.
module pr_guard_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_re,
    input logic       mem_rvalid,
    input logic [7:0] mem_rdata,
    input logic       rd_par,
    input logic       mask_q,
    input logic       flag_q,
    input logic       rst_req,
    input logic       reg_we,
    input logic       reg_bit_mode,
    input logic [2:0] reg_bit_sel,
    input logic [7:0] reg_wdata
);
    logic sw_clear;
    always_comb sw_clear = reg_we && (reg_bit_mode ? (reg_bit_sel == 3'd0 && !reg_wdata[0])
                                                   : !reg_wdata[0]);

    // R1: read-valid follows a read request by one cycle.
    a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_rvalid);
    a_r1_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !mem_rvalid);
    // R3: odd parity on a valid read sets the flag next cycle.
    a_r3_detect_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && (^{rd_par, mem_rdata})) |=> flag_q);
    // R4: every reset request is caused by an error detected the cycle before.
    a_r4_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(mem_rvalid && (^{rd_par, mem_rdata})));
    // R4: a reset request coincides with a set flag.
    a_r4_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flag_q);
    // R5: no reset request while the mask was set.
    a_r5_masked_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(mask_q));
    // R6: flag holds unless software clears it.
    a_r6_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !sw_clear) |=> flag_q);
endmodule

bind parity_ram_guard pr_guard_sva u_guard_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_re       (mem_re),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .rd_par       (rd_par),
    .mask_q       (mask_q),
    .flag_q       (flag_q),
    .rst_req      (rst_req),
    .reg_we       (reg_we),
    .reg_bit_mode (reg_bit_mode),
    .reg_bit_sel  (reg_bit_sel),
    .reg_wdata    (reg_wdata)
);

// File: tb/test_parity_ram_guard.sv
module test_parity_ram_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic          mem_we = 1'b0;
    logic          mem_re = 1'b0;
    logic          inj_par_flip = 1'b0;
    logic [7:0]    mem_rdata;
    logic          mem_rvalid;
    logic          reg_we = 1'b0;
    logic          reg_bit_mode = 1'b0;
    logic [2:0]    reg_bit_sel = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          rst_req;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] m_data [DEPTH];
    bit         m_flip [DEPTH];
    bit         m_valid [DEPTH];
    bit         e_mask = 0;
    bit         e_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_ram_guard #(.ADDR_W(AW)) i_parity_ram_guard (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .inj_par_flip(inj_par_flip),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .reg_we(reg_we),
        .reg_bit_mode(reg_bit_mode), .reg_bit_sel(reg_bit_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req)
    );

    function automatic logic [7:0] exp_reg();
        return {e_mask, 6'b0, e_flag};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic mem_write(input logic [AW-1:0] a, input logic [7:0] d, input bit fl);
        @(negedge clk);
        mem_addr = a; mem_wdata = d; mem_we = 1'b1; inj_par_flip = fl;
        @(negedge clk);
        mem_we = 1'b0; inj_par_flip = 1'b0;
        m_data[a] = d; m_flip[a] = fl; m_valid[a] = 1;
        // R11: a write alone never touches flag or reset request
        chk(reg_rdata == exp_reg(), "R11 reg after write", reg_rdata, exp_reg());
        chk(rst_req == 1'b0, "R11 rst_req after write", rst_req, 0);
    endtask

    // Optional same-cycle clear (R8) on the detection edge.
    task automatic mem_read(input logic [AW-1:0] a, input bit clash);
        bit err;
        bit e_req;
        err = m_flip[a];
        @(negedge clk);
        mem_addr = a; mem_re = 1'b1;
        @(negedge clk);
        mem_re = 1'b0;
        chk(mem_rvalid == 1'b1, "R1 rvalid", mem_rvalid, 1);
        chk(mem_rdata == m_data[a], "R1 rdata", mem_rdata, m_data[a]);
        if (clash) begin
            reg_we = 1'b1; reg_bit_mode = 1'b0; reg_wdata = {e_mask, 7'b0};
        end
        e_req = err && !e_mask;
        if (err) e_flag = 1;
        else if (clash) e_flag = 0;
        @(negedge clk);
        reg_we = 1'b0;
        chk(rst_req == e_req, err ? (e_mask ? "R5 masked req" : "R4 req pulse") : "R2 no req",
            rst_req, e_req);
        chk(reg_rdata == exp_reg(),
            clash ? "R8 set beats clear" : (err ? "R3 flag set" : "R6 flag sticky/R2 clean"),
            reg_rdata, exp_reg());
        @(negedge clk);
        chk(rst_req == 1'b0, "R4 single pulse", rst_req, 0);
        chk(mem_rvalid == 1'b0, "R1 rvalid drops", mem_rvalid, 0);
    endtask

    task automatic reg_write(input bit bm, input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_bit_mode = bm; reg_bit_sel = sel; reg_wdata = d;
        if (!bm) begin
            e_mask = d[7];
            if (!d[0]) e_flag = 0;
        end else if (sel == 3'd7) e_mask = d[7];
        else if (sel == 3'd0 && !d[0]) e_flag = 0;
        @(negedge clk);
        reg_we = 1'b0;
        chk(reg_rdata == exp_reg(), bm ? "R10 bit write" : "R7/R10 byte write", reg_rdata, exp_reg());
        chk(reg_rdata[6:1] == 6'b0, "R9 reserved zero", reg_rdata, exp_reg());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(reg_rdata == 8'h00, "R9 reset value", reg_rdata, 8'h00);
        chk(rst_req == 1'b0, "R9 rst_req at reset", rst_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: clean write and read
        mem_write(6'd3, 8'hA5, 0);
        mem_read(6'd3, 0);
        // R11/R3/R4: injected parity, unmasked
        mem_write(6'd9, 8'h3C, 1);
        mem_read(6'd9, 0);
        // R6: clean read keeps flag
        mem_read(6'd3, 0);
        // R7: writing 1 to flag leaves it; writing 0 clears it
        reg_write(0, 3'd0, 8'h01);
        reg_write(0, 3'd0, 8'h00);
        reg_write(0, 3'd0, 8'h01);
        // R10/R5: bit-mode set of mask, masked error
        reg_write(1, 3'd7, 8'h80);
        mem_read(6'd9, 0);
        // R10: bit-mode write to reserved bit, bit-mode clear of flag
        reg_write(1, 3'd4, 8'hFF);
        reg_write(1, 3'd0, 8'hFE);
        reg_write(1, 3'd7, 8'h7F);
        // R8: clash of hardware set and software clear
        mem_read(6'd9, 1);
        // R1: last word at boundary addresses
        mem_write(6'd63, 8'hFF, 0);
        mem_write(6'd0, 8'h00, 0);
        mem_read(6'd63, 0);
        mem_read(6'd0, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [AW-1:0] a;
            op = $urandom % 10;
            a = AW'($urandom);
            if (op < 4 || (op < 8 && !m_valid[a]))
                mem_write(a, 8'($urandom), ($urandom % 8) == 0);
            else if (op < 8)
                mem_read(a, 0);
            else
                reg_write(1'($urandom), 3'($urandom), 8'($urandom));
        end

        // R12: reset clears mask and flag
        reg_write(0, 3'd0, 8'h80);
        mem_read(6'd9, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        e_mask = 0; e_flag = 0;
        chk(reg_rdata == 8'h00, "R12 reset clears register", reg_rdata, 8'h00);
        report();
    end
endmodule